// File: doc/BRIEF.md
# Shadow RAM Segment Attribute Decoder

This block turns three byte-wide shadow-control words into routing attributes for the legacy ROM window from 0xC0000 to 0xFFFFF of a 1 MB real-mode address map. The window is split into twelve 16 KB option segments, 0xC0000 to 0xEFFFF, and one 64 KB system BIOS segment at 0xF0000. For each looked-up CPU address the block reports whether the address lies in the window, which segment it hits, where a read is served (internal DRAM or the external bus) and where a write goes (internal DRAM, the external bus, or nowhere). It does not run any DRAM or bus cycle.

Lookups arrive on a valid/ready request stream and leave on a valid/ready response stream through one register stage. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The control words are sampled in that same cycle. The response is presented on the next cycle and is held unchanged for as long as `rsp_ready` is low. `req_ready` is high whenever the response slot is empty or is being drained in the current cycle, so back-pressure on the response side stalls the request side without dropping or duplicating a lookup. The high-shadow flag is a plain status output derived from the live control words and is not part of the stream.

The control words are `cfg_mode` (copy mode, BIOS routing, per-group read-only and ROM-qualify bits), `cfg_en_hi` (enables for segments 4 to 11) and `cfg_en_lo` (enables for segments 0 to 3 and the BIOS write-steer bit).

Top module: `shadow_route_decoder`

## Requirements
- R1: Address a with a[19:18]=2'b11 lies in the window (`rsp_in_area`=1). Option segment i (0 to 11) covers 0xC0000+i*0x4000 to 0xC0000+i*0x4000+0x3FFF and reports `rsp_seg`=i. Addresses 0xF0000 to 0xFFFFF report `rsp_seg`=12.
- R2: When `cfg_mode[3]` (copy mode) is 1, every option segment reads the external bus (`rsp_rd_src`=0) and writes internal DRAM (`rsp_wr_tgt`=1), whatever its enable bit.
- R3: Outside copy mode, an option segment whose enable and ROM-qualify bits are both 1 reads DRAM (`rsp_rd_src`=1). It writes nowhere (`rsp_wr_tgt`=0) if its read-only bit is 1, and writes DRAM (`rsp_wr_tgt`=1) otherwise.
- R4: Outside copy mode, an option segment without both enable and ROM-qualify reads the external bus (`rsp_rd_src`=0) and writes nowhere (`rsp_wr_tgt`=0).
- R5: The enable of segment i<4 is `cfg_en_lo[i+4]`. The enable of segment i>=4 is `cfg_en_hi[i-4]`.
- R6: Segment i uses read-only bit `cfg_mode[i/4]` and ROM-qualify bit `cfg_mode[i/4+4]`, so each bit pair is shared by four segments.
- R7: When `cfg_mode[7]`=0, the BIOS segment reads DRAM (`rsp_rd_src`=1) and writes nowhere (`rsp_wr_tgt`=0).
- R8: When `cfg_mode[7]`=1, the BIOS segment reads the external bus. Writes go to the external bus (`rsp_wr_tgt`=2) if `cfg_en_lo[1]`=1, and to DRAM (`rsp_wr_tgt`=1) if it is 0.
- R9: `high_shadow` is 1 exactly when copy mode is on, or when some segment i>=4 has both its enable and its ROM-qualify bit set.
- R10: An address outside the window gives `rsp_in_area`=0, `rsp_seg`=15, `rsp_rd_src`=0 and `rsp_wr_tgt`=2.
- R11: An accepted request produces `rsp_valid`=1 on the next cycle. A response stalled by `rsp_ready`=0 keeps all response fields stable and holds `req_ready` low.
- R12: After reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 8 | Copy mode, BIOS routing, group read-only and ROM-qualify bits |
| cfg_en_hi | input | 8 | Enables for segments 4 to 11 |
| cfg_en_lo | input | 8 | Enables for segments 0 to 3 in [7:4]; BIOS write steer in [1] |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle when high with req_valid |
| req_addr | input | 20 | CPU address to look up |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_in_area | output | 1 | Address lies in 0xC0000 to 0xFFFFF |
| rsp_seg | output | 4 | Segment index: 0 to 11 option, 12 BIOS, 15 outside |
| rsp_rd_src | output | 1 | 1 = DRAM, 0 = external bus |
| rsp_wr_tgt | output | 2 | 0 = disabled, 1 = DRAM, 2 = external bus |
| high_shadow | output | 1 | Some segment at or above 0xD0000 is shadowed or copying |

## Verification
A wrong bit index in the enable or group selection shows up as a wrong `rsp_rd_src` or `rsp_wr_tgt` only for the segments that use that bit. Sweeping each segment with its own bit set and cleared exposes such a fault on the response one cycle after the lookup is accepted. A fault in the copy-mode or BIOS priority shows up as a wrong routing pair on the first lookup under the affected control pattern. A fault in the response register shows up as a changed field or a dropped `rsp_valid` during a stall. This is checked on every stalled cycle.

// File: rtl/shadow_dec_pkg.sv
package shadow_dec_pkg;
  localparam int unsigned SEG_CNT   = 12;
  localparam int unsigned GRP_SIZE  = 4;
  localparam int unsigned SEG_SHIFT = 14;
  localparam int unsigned IDX_W     = 4;

  localparam logic [IDX_W-1:0] IDX_BIOS = 4'd12;
  localparam logic [IDX_W-1:0] IDX_NONE = 4'd15;

  typedef enum logic {
    RD_BUS  = 1'b0,
    RD_DRAM = 1'b1
  } rd_src_e;

  typedef enum logic [1:0] {
    WR_OFF  = 2'd0,
    WR_DRAM = 2'd1,
    WR_BUS  = 2'd2
  } wr_tgt_e;

  typedef struct packed {
    rd_src_e rd;
    wr_tgt_e wr;
  } route_t;

  typedef struct packed {
    logic             in_area;
    logic [IDX_W-1:0] seg;
    route_t           route;
  } lookup_t;
endpackage

// File: rtl/shadow_seg_attr.sv
module shadow_seg_attr
  import shadow_dec_pkg::*;
#(
  parameter int unsigned NSEG  = SEG_CNT,
  parameter int unsigned GRP   = GRP_SIZE,
  parameter int unsigned HI_LO = 4
) (
  input  logic [7:0] cfg_mode,
  input  logic [7:0] cfg_en_hi,
  input  logic [7:0] cfg_en_lo,
  output route_t     seg_route [NSEG],
  output logic       high_any
);
  localparam int unsigned COPY_BIT = 3;
  localparam int unsigned ROM_OFS  = 4;

  logic [NSEG-1:0] hit_high;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic en_b, ro_b, rom_b, shadowed;
    if (i < GRP) begin : g_low
      assign en_b = cfg_en_lo[i+4];
    end else begin : g_high
      assign en_b = cfg_en_hi[i-GRP];
    end
    assign ro_b     = cfg_mode[i/GRP];
    assign rom_b    = cfg_mode[i/GRP + ROM_OFS];
    assign shadowed = en_b & rom_b;

    always_comb begin
      if (cfg_mode[COPY_BIT]) begin
        seg_route[i].rd = RD_BUS;
        seg_route[i].wr = WR_DRAM;
      end else if (shadowed) begin
        seg_route[i].rd = RD_DRAM;
        seg_route[i].wr = ro_b ? WR_OFF : WR_DRAM;
      end else begin
        seg_route[i].rd = RD_BUS;
        seg_route[i].wr = WR_OFF;
      end
    end

    if (i >= HI_LO) begin : g_hflag
      assign hit_high[i] = cfg_mode[COPY_BIT] | shadowed;
    end else begin : g_lflag
      assign hit_high[i] = 1'b0;
    end
  end

  assign high_any = |hit_high;
endmodule

// File: rtl/shadow_bios_attr.sv
module shadow_bios_attr
  import shadow_dec_pkg::*;
(
  input  logic [7:0] cfg_mode,
  input  logic [7:0] cfg_en_lo,
  output route_t     bios_route
);
  localparam int unsigned EXT_BIT   = 7;
  localparam int unsigned STEER_BIT = 1;

  always_comb begin
    if (!cfg_mode[EXT_BIT]) begin
      bios_route.rd = RD_DRAM;
      bios_route.wr = WR_OFF;
    end else begin
      bios_route.rd = RD_BUS;
      bios_route.wr = cfg_en_lo[STEER_BIT] ? WR_BUS : WR_DRAM;
    end
  end
endmodule

// File: rtl/shadow_addr_match.sv
module shadow_addr_match
  import shadow_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NSEG   = SEG_CNT
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_area,
  output logic [IDX_W-1:0]  seg
);
  localparam int unsigned WIN_LSB = 18;
  logic [IDX_W-1:0] raw_idx;

  if (ADDR_W > 20) begin : g_wide
    assign in_area = (addr[ADDR_W-1:20] == '0) && (addr[19:WIN_LSB] == 2'b11);
  end else begin : g_exact
    assign in_area = (addr[19:WIN_LSB] == 2'b11);
  end

  assign raw_idx = addr[SEG_SHIFT +: IDX_W];

  always_comb begin
    if (!in_area)                    seg = IDX_NONE;
    else if (raw_idx >= IDX_W'(NSEG)) seg = IDX_BIOS;
    else                             seg = raw_idx;
  end
endmodule

// File: rtl/shadow_route_decoder.sv
module shadow_route_decoder
  import shadow_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_mode,
  input  logic [7:0]        cfg_en_hi,
  input  logic [7:0]        cfg_en_lo,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_in_area,
  output logic [3:0]        rsp_seg,
  output logic              rsp_rd_src,
  output logic [1:0]        rsp_wr_tgt,
  output logic              high_shadow
);
  route_t          seg_route [SEG_CNT];
  route_t          bios_route;
  logic            hit_in;
  logic [IDX_W-1:0] hit_seg;
  lookup_t         nxt, cur;
  logic            fire;

  shadow_seg_attr #(.NSEG(SEG_CNT), .GRP(GRP_SIZE), .HI_LO(GRP_SIZE)) u_seg (
    .cfg_mode (cfg_mode),
    .cfg_en_hi(cfg_en_hi),
    .cfg_en_lo(cfg_en_lo),
    .seg_route(seg_route),
    .high_any (high_shadow)
  );

  shadow_bios_attr u_bios (
    .cfg_mode  (cfg_mode),
    .cfg_en_lo (cfg_en_lo),
    .bios_route(bios_route)
  );

  shadow_addr_match #(.ADDR_W(ADDR_W), .NSEG(SEG_CNT)) u_match (
    .addr   (req_addr),
    .in_area(hit_in),
    .seg    (hit_seg)
  );

  always_comb begin
    nxt.in_area = hit_in;
    nxt.seg     = hit_seg;
    if (!hit_in) begin
      nxt.route.rd = RD_BUS;
      nxt.route.wr = WR_BUS;
    end else if (hit_seg == IDX_BIOS) begin
      nxt.route = bios_route;
    end else begin
      nxt.route = seg_route[hit_seg];
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      cur       <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      cur       <= nxt;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_in_area = cur.in_area;
  assign rsp_seg     = cur.seg;
  assign rsp_rd_src  = cur.route.rd;
  assign rsp_wr_tgt  = cur.route.wr;
endmodule

// File: rtl/shadow_route_decoder_chk.sv
module shadow_route_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_mode,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic       rsp_in_area,
  input logic [3:0] rsp_seg,
  input logic       rsp_rd_src,
  input logic [1:0] rsp_wr_tgt,
  input logic       high_shadow
);
  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_seg) && $stable(rsp_in_area)
      && $stable(rsp_rd_src) && $stable(rsp_wr_tgt));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_in_area |-> rsp_seg == 4'd15 && !rsp_rd_src && rsp_wr_tgt == 2'd2);

  assert_segrange_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_in_area |-> rsp_seg <= 4'd12);

  assert_busw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_in_area && rsp_wr_tgt == 2'd2 |-> rsp_seg == 4'd12 && !rsp_rd_src);

  assert_biosdram_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_seg == 4'd12 && rsp_rd_src |-> rsp_wr_tgt == 2'd0);

  assert_copyflag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode[3] |-> high_shadow);

  assert_nowrcode3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_wr_tgt != 2'd3);
endmodule

bind shadow_route_decoder shadow_route_decoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_mode   (cfg_mode),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_in_area(rsp_in_area),
  .rsp_seg    (rsp_seg),
  .rsp_rd_src (rsp_rd_src),
  .rsp_wr_tgt (rsp_wr_tgt),
  .high_shadow(high_shadow)
);

// File: tb/shadow_route_decoder_tb_top.sv
module shadow_route_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_mode = 8'h00, cfg_en_hi = 8'h00, cfg_en_lo = 8'h00;
  logic        req_valid = 1'b0, rsp_ready = 1'b1;
  logic [19:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_in_area, rsp_rd_src, high_shadow;
  logic [3:0]  rsp_seg;
  logic [1:0]  rsp_wr_tgt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  shadow_route_decoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_mode(cfg_mode), .cfg_en_hi(cfg_en_hi), .cfg_en_lo(cfg_en_lo),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_in_area(rsp_in_area), .rsp_seg(rsp_seg),
    .rsp_rd_src(rsp_rd_src), .rsp_wr_tgt(rsp_wr_tgt),
    .high_shadow(high_shadow)
  );

  // expected: {in_area, seg[3:0], rd, wr[1:0]}
  function automatic logic [7:0] model(input logic [19:0] a, input logic [7:0] m,
                                       input logic [7:0] h, input logic [7:0] l);
    int s;
    logic en, ro, rom;
    if (a < 20'hC0000) return {1'b0, 4'd15, 1'b0, 2'd2};
    if (a >= 20'hF0000) begin
      if (!m[7]) return {1'b1, 4'd12, 1'b1, 2'd0};
      return {1'b1, 4'd12, 1'b0, (l[1] ? 2'd2 : 2'd1)};
    end
    s   = int'((a - 20'hC0000) / 20'h4000);
    en  = (s < 4) ? l[s+4] : h[s-4];
    ro  = m[s/4];
    rom = m[s/4 + 4];
    if (m[3])       return {1'b1, 4'(s), 1'b0, 2'd1};
    if (en && rom)  return {1'b1, 4'(s), 1'b1, (ro ? 2'd0 : 2'd1)};
    return {1'b1, 4'(s), 1'b0, 2'd0};
  endfunction

  function automatic logic model_high(input logic [7:0] m, input logic [7:0] h);
    logic r = m[3];
    for (int s = 4; s < 12; s++) r |= h[s-4] & m[s/4 + 4];
    return r;
  endfunction

  function automatic string tag_of(input logic [19:0] a, input logic [7:0] m,
                                   input logic [7:0] h, input logic [7:0] l);
    logic [7:0] e = model(a, m, h, l);
    if (!e[7])         return "R10";
    if (e[6:3] == 12)  return m[7] ? "R8" : "R7";
    if (m[3])          return "R2";
    if (e[2])          return "R3";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [19:0] a, input string tag);
    @(negedge clk);
    req_addr  = a;
    req_valid = 1'b1;
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 valid", {7'd0, rsp_valid}, 8'd1);
    check(tag, {rsp_in_area, rsp_seg, rsp_rd_src, rsp_wr_tgt},
          model(a, cfg_mode, cfg_en_hi, cfg_en_lo));
    check("R9", {7'd0, high_shadow}, {7'd0, model_high(cfg_mode, cfg_en_hi)});
  endtask

  task automatic set_cfg(input logic [7:0] m, input logic [7:0] h, input logic [7:0] l);
    @(negedge clk);
    cfg_mode = m; cfg_en_hi = h; cfg_en_lo = l;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12", {6'd0, rsp_valid, req_ready}, 8'h01);

    // R1 / R10: boundaries with everything off
    set_cfg(8'h00, 8'h00, 8'h00);
    lookup(20'hBFFFF, "R10");
    lookup(20'h00000, "R10");
    lookup(20'hC0000, "R1");
    lookup(20'hC3FFF, "R1");
    lookup(20'hC4000, "R1");
    lookup(20'hEFFFF, "R1");
    lookup(20'hF0000, "R7");
    lookup(20'hFFFFF, "R7");

    // R5 / R6: each segment's own enable with its group's ROM-qualify, read-only toggled
    for (int s = 0; s < 12; s++) begin
      logic [7:0] h = (s >= 4) ? (8'h01 << (s - 4)) : 8'h00;
      logic [7:0] l = (s < 4)  ? (8'h10 << s) : 8'h00;
      logic [19:0] a = 20'hC0000 + 20'(s) * 20'h4000 + 20'h123;
      set_cfg(8'h80 | (8'h10 << (s / 4)), h, l);
      lookup(a, "R5");
      set_cfg(8'h80 | (8'h11 << (s / 4)), h, l);
      lookup(a, "R6");
      // neighbour in the same group sees no enable
      lookup(20'hC0000 + 20'(((s / 4) * 4) + ((s + 1) % 4)) * 20'h4000, "R4");
    end

    // R2: copy mode overrides enables off and on
    set_cfg(8'h08, 8'h00, 8'h00);
    lookup(20'hC8000, "R2");
    set_cfg(8'h7F, 8'hFF, 8'hF0);
    lookup(20'hE4000, "R2");
    lookup(20'hF8000, "R7");

    // R8: both BIOS steer settings
    set_cfg(8'h80, 8'h00, 8'h02);
    lookup(20'hF1234, "R8");
    set_cfg(8'h80, 8'h00, 8'h00);
    lookup(20'hF1234, "R8");

    // R9: only low group shadowed -> flag low
    set_cfg(8'h10, 8'h00, 8'hF0);
    lookup(20'hC0000, "R9");

    // R11: stall holds response and blocks request side
    set_cfg(8'h00, 8'h00, 8'h00);
    @(negedge clk);
    req_addr = 20'hF0000; req_valid = 1'b1; rsp_ready = 1'b0;
    @(negedge clk);
    held = {rsp_in_area, rsp_seg, rsp_rd_src, rsp_wr_tgt};
    check("R11 first", held, model(20'hF0000, 8'h00, 8'h00, 8'h00));
    req_addr = 20'h12345; cfg_mode = 8'h80;
    repeat (3) begin
      @(negedge clk);
      check("R11 hold", {rsp_valid, req_ready, 6'd0}, 8'h80);
      check("R11 stable", {rsp_in_area, rsp_seg, rsp_rd_src, rsp_wr_tgt}, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 next", {rsp_in_area, rsp_seg, rsp_rd_src, rsp_wr_tgt},
          model(20'h12345, 8'h80, 8'h00, 8'h00));

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [19:0] a;
      set_cfg(8'($urandom), 8'($urandom), 8'($urandom));
      if (($urandom % 8) == 0) a = 20'($urandom);
      else a = 20'hC0000 + 20'($urandom % 32'h40000);
      lookup(a, tag_of(a, cfg_mode, cfg_en_hi, cfg_en_lo));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule